// File: doc/BRIEF.md
# Lost-Cell Dummy Payload Inserter

This block serves one port on the receive side of a cell reassembly path. When an upstream sequence checker reports that cells went missing, or when the port's late-arrival timer expires while the port is in sync, the block writes filler cells into the port's circular reassembly buffer. Each filler cell is 47 copies of a programmable filler octet. By default that octet is the silence pattern 0xFF. Writes go out one octet per clock through a simple byte-write port.

Software-visible settings are held in two small register groups, each loaded by its own strobe. The first group holds the filler octet. The second holds the count mode, the late-check enable, the global enable and the rollover-summary enable.

The count mode selects how many filler cells a loss produces. In exact mode the number equals the reported loss, capped at seven. In the default clamped mode a loss produces at most two cells. Loss-caused and late-caused filler cells are counted in separate counters. A wrap of the loss counter produces a one-cycle pulse, and that pulse is forwarded to a summary output only when the rollover-summary enable is set.

Top module: `fci_top`

## Requirements
- R1: A filler cell is exactly 47 buffer writes on consecutive clocks while enabled. Every write carries the current filler octet, and each write goes to the address after the previous one. Back-to-back cells follow without a gap.
- R2: After reset the filler octet is 0xFF. A pulse on `cfg_fill_wr` replaces it with `cfg_fill_octet`.
- R3: With `cfg_exact_mode`=1, a loss event with count n produces min(n,7) filler cells.
- R4: With `cfg_exact_mode`=0, which is the reset value, a loss event with count n produces min(n,2) filler cells. A count of 0 produces no cell in either mode.
- R5: A `late_tmo` pulse produces one filler cell only when `cfg_late_chk`=1 and `in_sync`=1. The late check is off at reset.
- R6: The global enable is 0 at reset. While it is 0, events are discarded and no buffer write occurs. A cell already in progress pauses, and it resumes where it stopped once the enable is set again.
- R7: The write address is 0 after reset. It advances by one per write and wraps from BUF_DEPTH-1 to 0.
- R8: `busy` is high from the cycle after an accepted event until the last filler octet has been written. Requests arriving during writing are queued, and each queue (loss and late) saturates at 7 pending cells.
- R9: `lost_cells` increments once per completed loss-caused cell, and `late_cells` increments once per completed late-caused cell. Both counters are 0 at reset.
- R10: When `lost_cells` wraps from all ones to 0, `lost_roll` pulses for one cycle. `roll_irq` pulses in the same cycle only if `cfg_roll_irq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fill_wr | input | 1 | Load strobe for the filler octet |
| cfg_fill_octet | input | 8 | New filler octet |
| cfg_ctl_wr | input | 1 | Load strobe for the control bits |
| cfg_exact_mode | input | 1 | 1: cells = lost count (cap 7); 0: cap 2 |
| cfg_late_chk | input | 1 | Enables filler on late timeout |
| cfg_glob_en | input | 1 | Global insertion enable |
| cfg_roll_irq_en | input | 1 | Forwards loss-counter rollover to `roll_irq` |
| loss_vld | input | 1 | Loss event strobe |
| loss_cnt | input | LOSS_W | Number of lost cells reported |
| in_sync | input | 1 | Port is in sync |
| late_tmo | input | 1 | Late-cell timeout pulse |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | AW | Buffer write address |
| buf_data | output | 8 | Buffer write octet |
| busy | output | 1 | Filler pending or being written |
| lost_cells | output | CNT_W | Loss-caused filler cell count |
| late_cells | output | CNT_W | Late-caused filler cell count |
| lost_roll | output | 1 | One-cycle pulse on loss counter wrap |
| roll_irq | output | 1 | Gated rollover summary pulse |

## Verification
The hardest states to reach are a saturated pending queue and a counter wrap. Saturation only occurs when a second large loss arrives while the first cell is still being written. The bench therefore issues a seven-cell loss, waits ten cycles into the first cell and issues another. The 16-bit counter wrap would take millions of cycles, so the bench builds the block with a 4-bit counter and a non-power-of-two buffer depth. It then pauses the global enable mid-cell to show that writing stalls and later resumes with the addresses still contiguous.

// File: rtl/fci_pkg.sv
package fci_pkg;

   typedef enum logic {
      KIND_LOSS = 1'b0,
      KIND_LATE = 1'b1
   } fill_kind_e;

   typedef struct packed {
      logic [7:0] fill_octet;
      logic       exact_mode;
      logic       late_chk;
      logic       glob_en;
      logic       roll_irq_en;
   } fci_cfg_t;

   localparam logic [7:0] SILENCE_OCTET = 8'hFF;

endpackage

// File: rtl/fci_cfg_regs.sv
module fci_cfg_regs
   import fci_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fill_wr,
   input  logic [7:0] fill_in,
   input  logic       ctl_wr,
   input  logic       exact_in,
   input  logic       late_in,
   input  logic       en_in,
   input  logic       roll_in,
   output fci_cfg_t   cfg_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q.fill_octet  <= SILENCE_OCTET;
         cfg_q.exact_mode  <= 1'b0;
         cfg_q.late_chk    <= 1'b0;
         cfg_q.glob_en     <= 1'b0;
         cfg_q.roll_irq_en <= 1'b0;
      end else begin
         if (fill_wr) cfg_q.fill_octet <= fill_in;
         if (ctl_wr) begin
            cfg_q.exact_mode  <= exact_in;
            cfg_q.late_chk    <= late_in;
            cfg_q.glob_en     <= en_in;
            cfg_q.roll_irq_en <= roll_in;
         end
      end
   end

   // R2: the filler octet comes out of reset as silence
   p_fill_reset_r2: assert property (@(posedge clk)
      $rose(rst_n) |-> cfg_q.fill_octet == SILENCE_OCTET);

endmodule

// File: rtl/fci_req_queue.sv
module fci_req_queue
   import fci_pkg::*;
#(
   parameter int LOSS_W     = 4,
   parameter int MAX_LOST   = 7,
   parameter int CLAMP_LOST = 2,
   parameter int PEND_MAX   = 7,
   localparam int PEND_W    = $clog2(PEND_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fci_cfg_t          cfg,
   input  logic              loss_vld,
   input  logic [LOSS_W-1:0] loss_cnt,
   input  logic              in_sync,
   input  logic              late_tmo,
   input  logic              take_loss,
   input  logic              take_late,
   output logic              pend_loss_any,
   output logic              pend_late_any
);

   if (CLAMP_LOST > MAX_LOST) begin : g_bad_clamp
      $error("CLAMP_LOST must not exceed MAX_LOST");
   end
   if (PEND_MAX < MAX_LOST) begin : g_bad_pend
      $error("PEND_MAX must hold one full loss request");
   end

   logic [PEND_W-1:0] pend_loss_q, pend_late_q;
   int loss_cap, loss_req, loss_next, late_next;
   logic late_hit;

   function automatic int sat_step(input int cur, input int dec, input int inc);
      int v;
      v = cur - dec + inc;
      if (v > PEND_MAX) v = PEND_MAX;
      if (v < 0) v = 0;
      return v;
   endfunction

   always_comb begin
      loss_cap = cfg.exact_mode ? MAX_LOST : CLAMP_LOST;
      loss_req = (int'(loss_cnt) > loss_cap) ? loss_cap : int'(loss_cnt);
      if (!(loss_vld && cfg.glob_en)) loss_req = 0;
      late_hit = late_tmo & cfg.late_chk & in_sync & cfg.glob_en;
      loss_next = sat_step(int'(pend_loss_q), int'(take_loss), loss_req);
      late_next = sat_step(int'(pend_late_q), int'(take_late), int'(late_hit));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_loss_q <= '0;
         pend_late_q <= '0;
      end else begin
         pend_loss_q <= PEND_W'(loss_next);
         pend_late_q <= PEND_W'(late_next);
      end
   end

   assign pend_loss_any = (pend_loss_q != '0);
   assign pend_late_any = (pend_late_q != '0);

   // R8: the engine never takes a cell that was not queued
   p_take_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_loss |-> pend_loss_q != '0);
   p_take_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_late |-> pend_late_q != '0);

endmodule

// File: rtl/fci_write_engine.sv
module fci_write_engine
   import fci_pkg::*;
#(
   parameter int BUF_DEPTH   = 256,
   parameter int CELL_OCTETS = 47,
   localparam int AW         = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
   localparam int OCT_W      = $clog2(CELL_OCTETS),
   localparam bit DEPTH_POW2 = ((BUF_DEPTH & (BUF_DEPTH - 1)) == 0)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [7:0]    fill,
   input  logic          pend_loss_any,
   input  logic          pend_late_any,
   output logic          buf_we,
   output logic [AW-1:0] buf_addr,
   output logic [7:0]    buf_data,
   output logic          take_loss,
   output logic          take_late,
   output logic          cell_done,
   output fill_kind_e    done_kind,
   output logic          active_o
);

   if (BUF_DEPTH < 2) begin : g_bad_depth
      $error("BUF_DEPTH must be at least 2");
   end
   if (CELL_OCTETS < 2) begin : g_bad_cell
      $error("CELL_OCTETS must be at least 2");
   end

   logic             active_q;
   fill_kind_e       kind_q;
   logic [OCT_W-1:0] oct_q;
   logic [AW-1:0]    wptr_q, wptr_inc;
   logic             last_oct, take_any;

   if (DEPTH_POW2) begin : g_wrap_pow2
      assign wptr_inc = wptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_inc = (wptr_q == AW'(BUF_DEPTH - 1)) ? '0 : wptr_q + 1'b1;
   end

   assign buf_we    = active_q & en;
   assign last_oct  = (oct_q == OCT_W'(CELL_OCTETS - 1));
   assign cell_done = buf_we & last_oct;
   assign take_any  = en & (~active_q | cell_done) & (pend_loss_any | pend_late_any);
   assign take_loss = take_any & pend_loss_any;
   assign take_late = take_any & ~pend_loss_any;
   assign buf_addr  = wptr_q;
   assign buf_data  = fill;
   assign done_kind = kind_q;
   assign active_o  = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         kind_q   <= KIND_LOSS;
         oct_q    <= '0;
         wptr_q   <= '0;
      end else begin
         if (take_any) begin
            active_q <= 1'b1;
            kind_q   <= take_loss ? KIND_LOSS : KIND_LATE;
            oct_q    <= '0;
         end else if (cell_done) begin
            active_q <= 1'b0;
         end else if (buf_we) begin
            oct_q <= oct_q + 1'b1;
         end
         if (buf_we) wptr_q <= wptr_inc;
      end
   end

   // R7: the last buffer slot is followed by slot zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_addr == AW'(BUF_DEPTH - 1)) |=> buf_addr == '0);
   // R6: no write progress while disabled
   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(buf_addr));
   // R1: a cell that is not at its last octet keeps the engine active
   p_cell_cont_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && !last_oct) |=> active_q);

endmodule

// File: rtl/fci_cell_counters.sv
module fci_cell_counters
   import fci_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cell_done,
   input  fill_kind_e       done_kind,
   input  logic             roll_irq_en,
   output logic [CNT_W-1:0] lost_cells,
   output logic [CNT_W-1:0] late_cells,
   output logic             lost_roll,
   output logic             roll_irq
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic loss_done, late_done, wrap_now;

   assign loss_done = cell_done & (done_kind == KIND_LOSS);
   assign late_done = cell_done & (done_kind == KIND_LATE);
   assign wrap_now  = loss_done & (&lost_cells);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_cells <= '0;
         late_cells <= '0;
         lost_roll  <= 1'b0;
         roll_irq   <= 1'b0;
      end else begin
         if (loss_done) lost_cells <= lost_cells + 1'b1;
         if (late_done) late_cells <= late_cells + 1'b1;
         lost_roll <= wrap_now;
         roll_irq  <= wrap_now & roll_irq_en;
      end
   end

   // R10: a rollover pulse coincides with a zero count
   p_roll_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lost_roll |-> lost_cells == '0);
   // R10: the summary never fires without a rollover
   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      roll_irq |-> lost_roll);
   // R9: late cells leave the loss counter alone
   p_late_sep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      late_done |=> $stable(lost_cells));

endmodule

// File: rtl/fci_top.sv
module fci_top
   import fci_pkg::*;
#(
   parameter int BUF_DEPTH   = 256,
   parameter int CELL_OCTETS = 47,
   parameter int LOSS_W      = 4,
   parameter int MAX_LOST    = 7,
   parameter int CLAMP_LOST  = 2,
   parameter int PEND_MAX    = 7,
   parameter int CNT_W       = 16,
   localparam int AW         = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_fill_wr,
   input  logic [7:0]        cfg_fill_octet,
   input  logic              cfg_ctl_wr,
   input  logic              cfg_exact_mode,
   input  logic              cfg_late_chk,
   input  logic              cfg_glob_en,
   input  logic              cfg_roll_irq_en,
   input  logic              loss_vld,
   input  logic [LOSS_W-1:0] loss_cnt,
   input  logic              in_sync,
   input  logic              late_tmo,
   output logic              buf_we,
   output logic [AW-1:0]     buf_addr,
   output logic [7:0]        buf_data,
   output logic              busy,
   output logic [CNT_W-1:0]  lost_cells,
   output logic [CNT_W-1:0]  late_cells,
   output logic              lost_roll,
   output logic              roll_irq
);

   fci_cfg_t   cfg;
   logic       pend_loss_any, pend_late_any;
   logic       take_loss, take_late, cell_done, active;
   fill_kind_e done_kind;

   fci_cfg_regs u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_wr  (cfg_fill_wr),
      .fill_in  (cfg_fill_octet),
      .ctl_wr   (cfg_ctl_wr),
      .exact_in (cfg_exact_mode),
      .late_in  (cfg_late_chk),
      .en_in    (cfg_glob_en),
      .roll_in  (cfg_roll_irq_en),
      .cfg_q    (cfg)
   );

   fci_req_queue #(
      .LOSS_W     (LOSS_W),
      .MAX_LOST   (MAX_LOST),
      .CLAMP_LOST (CLAMP_LOST),
      .PEND_MAX   (PEND_MAX)
   ) u_queue (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg           (cfg),
      .loss_vld      (loss_vld),
      .loss_cnt      (loss_cnt),
      .in_sync       (in_sync),
      .late_tmo      (late_tmo),
      .take_loss     (take_loss),
      .take_late     (take_late),
      .pend_loss_any (pend_loss_any),
      .pend_late_any (pend_late_any)
   );

   fci_write_engine #(
      .BUF_DEPTH   (BUF_DEPTH),
      .CELL_OCTETS (CELL_OCTETS)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (cfg.glob_en),
      .fill          (cfg.fill_octet),
      .pend_loss_any (pend_loss_any),
      .pend_late_any (pend_late_any),
      .buf_we        (buf_we),
      .buf_addr      (buf_addr),
      .buf_data      (buf_data),
      .take_loss     (take_loss),
      .take_late     (take_late),
      .cell_done     (cell_done),
      .done_kind     (done_kind),
      .active_o      (active)
   );

   fci_cell_counters #(
      .CNT_W (CNT_W)
   ) u_counters (
      .clk         (clk),
      .rst_n       (rst_n),
      .cell_done   (cell_done),
      .done_kind   (done_kind),
      .roll_irq_en (cfg.roll_irq_en),
      .lost_cells  (lost_cells),
      .late_cells  (late_cells),
      .lost_roll   (lost_roll),
      .roll_irq    (roll_irq)
   );

   assign busy = active | pend_loss_any | pend_late_any;

   // R8: every write happens while busy is shown
   p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> busy);
   // R6: the global enable gates every write
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.glob_en |-> !buf_we);

endmodule

// File: tb/fci_top_tb_top.sv
`timescale 1ns/1ps
module fci_top_tb_top;

   localparam int DEPTH = 40;
   localparam int CELL  = 47;
   localparam int CW    = 4;
   localparam int NVEC  = 9;
   // {exact_mode, loss count, expected cells}
   localparam logic [8:0] VEC [0:NVEC-1] = '{
      {1'b0, 4'd1, 4'd1}, {1'b0, 4'd2, 4'd2}, {1'b0, 4'd5, 4'd2},
      {1'b0, 4'd0, 4'd0}, {1'b1, 4'd1, 4'd1}, {1'b1, 4'd5, 4'd5},
      {1'b1, 4'd7, 4'd7}, {1'b1, 4'd9, 4'd7}, {1'b1, 4'd0, 4'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_fill_wr = 0, cfg_ctl_wr = 0;
   logic [7:0] cfg_fill_octet = 8'h00;
   logic cfg_exact_mode = 0, cfg_late_chk = 0, cfg_glob_en = 0, cfg_roll_irq_en = 0;
   logic loss_vld = 0, in_sync = 0, late_tmo = 0;
   logic [3:0] loss_cnt = '0;
   logic buf_we, busy, lost_roll, roll_irq;
   logic [5:0] buf_addr;
   logic [7:0] buf_data;
   logic [CW-1:0] lost_cells, late_cells;

   int checks = 0, errors = 0, cyc = 0;
   int writes = 0, wr_bad = 0, exp_ptr = 0, rolls = 0, irqs = 0;
   int exp_loss = 0, exp_late = 0;
   logic [7:0] exp_fill = 8'hFF;

   always #2 clk = ~clk;

   fci_top #(.BUF_DEPTH(DEPTH), .CELL_OCTETS(CELL), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_fill_wr(cfg_fill_wr), .cfg_fill_octet(cfg_fill_octet),
      .cfg_ctl_wr(cfg_ctl_wr), .cfg_exact_mode(cfg_exact_mode),
      .cfg_late_chk(cfg_late_chk), .cfg_glob_en(cfg_glob_en),
      .cfg_roll_irq_en(cfg_roll_irq_en),
      .loss_vld(loss_vld), .loss_cnt(loss_cnt), .in_sync(in_sync), .late_tmo(late_tmo),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .busy(busy),
      .lost_cells(lost_cells), .late_cells(late_cells),
      .lost_roll(lost_roll), .roll_irq(roll_irq)
   );

   always @(negedge clk) begin
      if (rst_n && buf_we) begin
         writes++;
         if (buf_data !== exp_fill || int'(buf_addr) != exp_ptr) begin
            wr_bad++;
            $display("FAIL R1/R7 write: addr %0d data %02h expected addr %0d data %02h",
                     buf_addr, buf_data, exp_ptr, exp_fill);
         end
         exp_ptr = (exp_ptr + 1) % DEPTH;
      end
      if (rst_n && lost_roll) rolls++;
      if (rst_n && roll_irq) irqs++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_ctl(input logic ex, input logic lt, input logic en, input logic ro);
      @(posedge clk); #1;
      cfg_exact_mode = ex; cfg_late_chk = lt; cfg_glob_en = en; cfg_roll_irq_en = ro;
      cfg_ctl_wr = 1;
      @(posedge clk); #1 cfg_ctl_wr = 0;
   endtask

   task automatic pulse_loss(input int n);
      @(posedge clk); #1 loss_vld = 1; loss_cnt = 4'(n);
      @(posedge clk); #1 loss_vld = 0;
   endtask

   task automatic pulse_late();
      @(posedge clk); #1 late_tmo = 1;
      @(posedge clk); #1 late_tmo = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int w0;
      int r0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R8 busy after reset", int'(busy), 0);
      chk("R6 no write after reset", int'(buf_we), 0);
      chk("R7 addr after reset", int'(buf_addr), 0);
      chk("R9 lost after reset", int'(lost_cells), 0);
      chk("R9 late after reset", int'(late_cells), 0);

      // R6: enable is off at reset, so a loss is discarded
      pulse_loss(5); wait_idle();
      chk("R6 disabled writes", writes, 0);
      chk("R6 disabled count", int'(lost_cells), 0);

      // R3 / R4 table; R2 default 0xFF is checked by the write monitor
      for (int i = 0; i < NVEC; i++) begin
         set_ctl(VEC[i][8], 1'b0, 1'b1, 1'b0);
         w0 = writes;
         pulse_loss(int'(VEC[i][7:4]));
         wait_idle();
         exp_loss += int'(VEC[i][3:0]);
         chk(VEC[i][8] ? "R3 exact writes" : "R4 clamp writes", writes - w0,
             int'(VEC[i][3:0]) * CELL);
         chk("R9 lost count", int'(lost_cells), exp_loss % 16);
      end
      chk("R2 default octet writes", wr_bad, 0);

      // R2: new filler octet
      @(posedge clk); #1 cfg_fill_octet = 8'h3C; cfg_fill_wr = 1;
      @(posedge clk); #1 cfg_fill_wr = 0; exp_fill = 8'h3C;
      w0 = writes; pulse_loss(1); wait_idle(); exp_loss += 1;
      chk("R2 new octet writes", writes - w0, CELL);
      chk("R2 new octet data", wr_bad, 0);

      // R5 late timeout
      set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
      in_sync = 1; w0 = writes; pulse_late(); wait_idle(); exp_late += 1;
      chk("R5 late in sync", writes - w0, CELL);
      chk("R9 late count", int'(late_cells), exp_late);
      chk("R9 lost unchanged by late", int'(lost_cells), exp_loss % 16);
      in_sync = 0; w0 = writes; pulse_late(); wait_idle();
      chk("R5 late out of sync", writes - w0, 0);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b0);
      in_sync = 1; w0 = writes; pulse_late(); wait_idle();
      chk("R5 late check off", writes - w0, 0);
      chk("R5 late count held", int'(late_cells), exp_late);

      // R8 queue saturation: 1 cell taken, 6 pending + 7 -> 7
      w0 = writes; pulse_loss(7);
      repeat (10) @(negedge clk);
      chk("R8 busy while writing", int'(busy), 1);
      pulse_loss(7); wait_idle(); exp_loss += 8;
      chk("R8 saturated queue writes", writes - w0, 8 * CELL);
      chk("R8 busy cleared", int'(busy), 0);

      // R6 pause mid-cell and resume
      w0 = writes; pulse_loss(3);
      repeat (8) @(negedge clk);
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk); r0 = writes;
      repeat (6) @(negedge clk);
      chk("R6 paused writes", writes - r0, 0);
      chk("R8 busy while paused", int'(busy), 1);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b0);
      wait_idle(); exp_loss += 3;
      chk("R6 resumed total", writes - w0, 3 * CELL);

      // R10 rollover with summary gated off, then on
      chk("R10 rollovers", rolls, exp_loss / 16);
      chk("R10 summary gated", irqs, 0);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
      r0 = rolls;
      for (int k = 0; k < 3; k++) begin
         pulse_loss(7); wait_idle(); exp_loss += 7;
      end
      chk("R10 rollovers after", rolls, exp_loss / 16);
      chk("R10 summary enabled", irqs, rolls - r0);
      chk("R9 lost final", int'(lost_cells), exp_loss % 16);
      chk("R1 all writes valid", wr_bad, 0);
      chk("R7 final address", int'(buf_addr), exp_ptr);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule